// File: doc/BRIEF.md
# Serial Interrupt Frame Generator

This block carries a peripheral's interrupt requests to the host over one shared, open-drain serial interrupt wire. Time on the wire is cut into frames. The host opens each frame with a start pulse. The frame then holds a fixed run of slots, one per interrupt number and a final slot for the system-management interrupt. Each slot is three clocks long. When its request input is active, the peripheral pulls the wire low in that slot's first clock. It drives the wire high in the second clock and lets go in the third.

There are two start modes. In continuous mode only the host starts frames. In quiet mode the peripheral may open a frame itself when a request is pending and the wire is idle. It does this by pulling the wire low for one clock, and the host then carries the start pulse on. The host picks the mode for the next idle period through the length of the stop pulse that ends each frame, and the block remembers what it saw. A local enable must also agree before the block will start a frame on its own. A clock-run request output asks the host to restart a stopped bus clock while an enabled request is pending.

The request inputs are plain levels and need no handshake. The block only takes part in the frames it sees on the wire, so it never applies back-pressure.

Top module: `serirq_gen`

## Requirements
- R1: After reset, serirq_oe_o is 0, mode_quiet_o is 0 (continuous) and clkrun_req_o is 0.
- R2: Edge 0 is the first rising clock edge that samples the wire high after a start pulse. Slot k, phase p (0 sample, 1 recovery, 2 turnaround) occupies the clock period after edge 3k+p. In the sample phase of an active, enabled slot, the block drives the wire low (serirq_oe_o=1, serirq_o=0).
- R3: In the recovery phase that follows a slot it pulled low, the block drives the wire high (serirq_oe_o=1, serirq_o=1). In that slot's turnaround phase it releases the wire.
- R4: A slot whose request input is inactive, or whose bit in SLOT_EN is 0, is left released in all three phases. With the default SLOT_EN of 17'h1FFFA, the IRQ0 and IRQ2 slots are never driven.
- R5: Request bit k (0 to 15) maps to slot k, IRQk. Bit 16 maps to the last slot, SMI. After the SMI slot the block waits for the stop pulse.
- R6: A stop pulse of exactly 2 low clocks sets mode_quiet_o to 1. A stop pulse of 3 or more low clocks sets it to 0. A 1-clock stop pulse leaves it unchanged. The new value shows from the edge that samples the wire high again.
- R7: A frame may be started by the block when quiet_en_i=1, mode_quiet_o=1, the block is idle, an enabled request is pending and the wire is high. The block then drives the wire low for exactly one clock and releases it in the next one.
- R8: While idle, the block never drives the wire if mode_quiet_o=0 or quiet_en_i=0, even when requests are pending.
- R9: clkrun_req_o is 1 in the clock after one in which clk_stop_i=1 and at least one enabled request is pending, and 0 otherwise.
- R10: The wire is driven high only in a recovery phase. serirq_o reads 1 whenever serirq_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_req_i | input | NUM_SLOTS | Level request per slot; bit 16 is SMI |
| quiet_en_i | input | 1 | Local permission to start frames in quiet mode |
| clk_stop_i | input | 1 | Host signals the bus clock is stopping or stopped |
| serirq_i | input | 1 | Resolved level of the serial interrupt wire |
| serirq_o | output | 1 | Value driven onto the wire when enabled |
| serirq_oe_o | output | 1 | Drive enable for the wire |
| mode_quiet_o | output | 1 | Recorded start mode: 1 quiet, 0 continuous |
| clkrun_req_o | output | 1 | Request to restart the bus clock |

## Verification
The bench uses the default parameters: 17 slots, SLOT_EN of 17'h1FFFA, and stop lengths of 2 clocks for quiet and 3 for continuous. With 17 slots it can walk a whole frame, check every phase of every slot and reach the SMI slot at the end. The mask value makes the IRQ0 and IRQ2 slots stay silent even when their inputs are raised. The short stop thresholds let 1-, 2-, 3- and 4-clock stop pulses cover the unchanged, quiet and continuous outcomes, including the case where the count goes past the continuous threshold.

// File: rtl/serirq_pkg.sv
package serirq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_SLOTS = 2'd2,
    ST_STOP  = 2'd3
  } frame_st_t;

  typedef enum logic [1:0] {
    PH_SAMPLE = 2'd0,
    PH_RECOV  = 2'd1,
    PH_TURN   = 2'd2
  } slot_ph_t;
endpackage

// File: rtl/serirq_frame_fsm.sv
module serirq_frame_fsm
  import serirq_pkg::*;
#(
  parameter int NUM_SLOTS  = 17,
  parameter int STOP_CNT_W = 3,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  line_i,
  input  logic                  quiet_start_ok_i,
  output frame_st_t             st_q_o,
  output frame_st_t             st_nxt_o,
  output logic [SLOT_W-1:0]     slot_nxt_o,
  output slot_ph_t              ph_nxt_o,
  output logic                  kick_nxt_o,
  output logic                  stop_done_o,
  output logic [STOP_CNT_W-1:0] stop_len_o
);
  localparam logic [SLOT_W-1:0]     LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [STOP_CNT_W-1:0] CNT_MAX   = '1;

  frame_st_t             st_q, st_n;
  logic [SLOT_W-1:0]     slot_q, slot_n;
  slot_ph_t              ph_q, ph_n;
  logic [STOP_CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    st_n        = st_q;
    slot_n      = slot_q;
    ph_n        = ph_q;
    cnt_n       = cnt_q;
    kick_nxt_o  = 1'b0;
    stop_done_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!line_i) begin
          st_n = ST_START;
        end else if (quiet_start_ok_i) begin
          st_n       = ST_START;
          kick_nxt_o = 1'b1;
        end
      end
      ST_START: begin
        if (line_i) begin
          st_n   = ST_SLOTS;
          slot_n = '0;
          ph_n   = PH_SAMPLE;
        end
      end
      ST_SLOTS: begin
        unique case (ph_q)
          PH_SAMPLE: ph_n = PH_RECOV;
          PH_RECOV:  ph_n = PH_TURN;
          default: begin
            if (slot_q == LAST_SLOT) begin
              st_n  = ST_STOP;
              cnt_n = '0;
            end else begin
              slot_n = slot_q + 1'b1;
              ph_n   = PH_SAMPLE;
            end
          end
        endcase
      end
      default: begin
        if (!line_i) begin
          if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
        end else if (cnt_q != '0) begin
          stop_done_o = 1'b1;
          st_n        = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
      ph_q   <= PH_SAMPLE;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_n;
      slot_q <= slot_n;
      ph_q   <= ph_n;
      cnt_q  <= cnt_n;
    end
  end

  assign st_q_o     = st_q;
  assign st_nxt_o   = st_n;
  assign slot_nxt_o = slot_n;
  assign ph_nxt_o   = ph_n;
  assign stop_len_o = cnt_q;

  AST_SLOT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SLOTS) |-> (slot_q <= LAST_SLOT)); // R5
  AST_SLOTS_REACH_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SLOTS && slot_q == LAST_SLOT && ph_q == PH_TURN) |=> (st_q == ST_STOP)); // R5
endmodule

// File: rtl/serirq_slot_drv.sv
module serirq_slot_drv
  import serirq_pkg::*;
#(
  parameter int               NUM_SLOTS = 17,
  parameter logic [NUM_SLOTS-1:0] SLOT_EN = 17'h1FFFA,
  localparam int              SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] req_i,
  input  frame_st_t            st_nxt_i,
  input  logic [SLOT_W-1:0]    slot_nxt_i,
  input  slot_ph_t             ph_nxt_i,
  input  logic                 kick_nxt_i,
  output logic                 req_any_o,
  output logic                 oe_o,
  output logic                 val_o,
  output logic                 in_slots_o
);
  logic [NUM_SLOTS-1:0] req_eff;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot_mask
    if (SLOT_EN[k]) begin : g_on
      assign req_eff[k] = req_i[k];
    end else begin : g_off
      assign req_eff[k] = 1'b0;
    end
  end

  assign req_any_o = |req_eff;

  logic oe_d, val_d, pull_d;
  logic oe_q, val_q, pulled_q, in_slots_q;

  always_comb begin
    oe_d   = 1'b0;
    val_d  = 1'b1;
    pull_d = 1'b0;
    if (kick_nxt_i) begin
      oe_d  = 1'b1;
      val_d = 1'b0;
    end else if (st_nxt_i == ST_SLOTS) begin
      if (ph_nxt_i == PH_SAMPLE && req_eff[slot_nxt_i]) begin
        oe_d   = 1'b1;
        val_d  = 1'b0;
        pull_d = 1'b1;
      end else if (ph_nxt_i == PH_RECOV && pulled_q) begin
        oe_d  = 1'b1;
        val_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      oe_q       <= 1'b0;
      val_q      <= 1'b1;
      pulled_q   <= 1'b0;
      in_slots_q <= 1'b0;
    end else begin
      oe_q       <= oe_d;
      val_q      <= val_d;
      pulled_q   <= pull_d;
      in_slots_q <= (st_nxt_i == ST_SLOTS);
    end
  end

  assign oe_o       = oe_q;
  assign val_o      = val_q;
  assign in_slots_o = in_slots_q;

  AST_LOW_THEN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && !val_q && in_slots_q) |=> (oe_q && val_q)); // R3
  AST_HIGH_THEN_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && val_q) |=> !oe_q); // R3
  AST_HIGH_IN_SLOTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && val_q) |-> in_slots_q); // R10
  AST_FLOAT_READS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_q |-> val_q); // R10
endmodule

// File: rtl/serirq_mode_trk.sv
module serirq_mode_trk #(
  parameter int STOP_CNT_W      = 3,
  parameter int STOP_QUIET_CLKS = 2,
  parameter int STOP_CONT_CLKS  = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  stop_done_i,
  input  logic [STOP_CNT_W-1:0] stop_len_i,
  output logic                  mode_quiet_o
);
  localparam logic [STOP_CNT_W-1:0] QUIET_LEN = STOP_CNT_W'(STOP_QUIET_CLKS);
  localparam logic [STOP_CNT_W-1:0] CONT_LEN  = STOP_CNT_W'(STOP_CONT_CLKS);

  logic quiet_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      quiet_q <= 1'b0;
    end else if (stop_done_i) begin
      if (stop_len_i == QUIET_LEN)     quiet_q <= 1'b1;
      else if (stop_len_i >= CONT_LEN) quiet_q <= 1'b0;
    end
  end

  assign mode_quiet_o = quiet_q;

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_done_i |=> $stable(quiet_q)); // R6
  AST_MODE_CONT_ON_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_done_i && stop_len_i >= CONT_LEN) |=> !quiet_q); // R6
endmodule

// File: rtl/serirq_gen.sv
module serirq_gen
  import serirq_pkg::*;
#(
  parameter int                   NUM_SLOTS       = 17,
  parameter logic [NUM_SLOTS-1:0] SLOT_EN         = 17'h1FFFA,
  parameter int                   STOP_QUIET_CLKS = 2,
  parameter int                   STOP_CONT_CLKS  = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] irq_req_i,
  input  logic                 quiet_en_i,
  input  logic                 clk_stop_i,
  input  logic                 serirq_i,
  output logic                 serirq_o,
  output logic                 serirq_oe_o,
  output logic                 mode_quiet_o,
  output logic                 clkrun_req_o
);
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int STOP_CNT_W = $clog2(STOP_CONT_CLKS + 1) + 1;

  frame_st_t             st_q, st_nxt;
  logic [SLOT_W-1:0]     slot_nxt;
  slot_ph_t              ph_nxt;
  logic                  kick_nxt, stop_done, req_any, in_slots, quiet_ok;
  logic [STOP_CNT_W-1:0] stop_len;

  assign quiet_ok = quiet_en_i & mode_quiet_o & req_any;

  serirq_frame_fsm #(
    .NUM_SLOTS (NUM_SLOTS),
    .STOP_CNT_W(STOP_CNT_W)
  ) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .line_i          (serirq_i),
    .quiet_start_ok_i(quiet_ok),
    .st_q_o          (st_q),
    .st_nxt_o        (st_nxt),
    .slot_nxt_o      (slot_nxt),
    .ph_nxt_o        (ph_nxt),
    .kick_nxt_o      (kick_nxt),
    .stop_done_o     (stop_done),
    .stop_len_o      (stop_len)
  );

  serirq_slot_drv #(
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_EN  (SLOT_EN)
  ) u_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (irq_req_i),
    .st_nxt_i  (st_nxt),
    .slot_nxt_i(slot_nxt),
    .ph_nxt_i  (ph_nxt),
    .kick_nxt_i(kick_nxt),
    .req_any_o (req_any),
    .oe_o      (serirq_oe_o),
    .val_o     (serirq_o),
    .in_slots_o(in_slots)
  );

  serirq_mode_trk #(
    .STOP_CNT_W     (STOP_CNT_W),
    .STOP_QUIET_CLKS(STOP_QUIET_CLKS),
    .STOP_CONT_CLKS (STOP_CONT_CLKS)
  ) u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stop_done_i (stop_done),
    .stop_len_i  (stop_len),
    .mode_quiet_o(mode_quiet_o)
  );

  logic clkrun_q;
  always_ff @(posedge clk_i) begin
    if (!rst_ni) clkrun_q <= 1'b0;
    else         clkrun_q <= clk_stop_i & req_any;
  end
  assign clkrun_req_o = clkrun_q;

  AST_KICK_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (serirq_oe_o && !serirq_o && !in_slots) |=> !serirq_oe_o); // R7
  AST_NO_SELF_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && (!mode_quiet_o || !quiet_en_i)) |=> !serirq_oe_o); // R8
  AST_CLKRUN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clkrun_req_o |-> $past(clk_stop_i)); // R9
endmodule

// File: tb/serirq_gen_bench.sv
module serirq_gen_bench;
  localparam int          NS   = 17;
  localparam logic [16:0] MASK = 17'h1FFFA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] req = '0;
  logic quiet_en = 1'b0, clk_stop = 1'b0, host_low = 1'b0;
  logic line, drv, drv_oe, mode_q, clkrun;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign line = (host_low || (drv_oe && !drv)) ? 1'b0 : 1'b1;

  serirq_gen u_serirq_gen (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .quiet_en_i(quiet_en),
    .clk_stop_i(clk_stop), .serirq_i(line), .serirq_o(drv),
    .serirq_oe_o(drv_oe), .mode_quiet_o(mode_q), .clkrun_req_o(clkrun)
  );

  // fields: [20:4] request bits, [3:1] stop length, [0] expected mode
  localparam logic [20:0] VEC [6] = '{
    {17'h00002, 3'd3, 1'b0},
    {17'h10000, 3'd2, 1'b1},
    {17'h18008, 3'd1, 1'b1},
    {17'h00005, 3'd4, 1'b0},
    {17'h1FFFF, 3'd2, 1'b1},
    {17'h05550, 3'd3, 1'b0}
  };

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // walks all slots; first call sits at the negedge after the start ends
  task automatic slots_check(input logic [NS-1:0] rq);
    for (int s = 0; s < NS; s++) begin
      for (int p = 0; p < 3; p++) begin
        logic act_low;
        string tg;
        act_low = rq[s] & MASK[s];
        @(negedge clk);
        tg = (s == NS - 1) ? "R5" : (!act_low ? "R4" : (p == 0 ? "R2" : "R3"));
        if (act_low && p == 0)      check(tg, {drv_oe, drv}, 2'b10);
        else if (act_low && p == 1) check(tg, {drv_oe, drv}, 2'b11);
        else                        check(tg, {drv_oe, drv}, 2'b01);
      end
    end
  endtask

  task automatic stop_pulse(input int len, input logic exp_mode);
    @(negedge clk);
    host_low = 1'b1;
    repeat (len) @(negedge clk);
    host_low = 1'b0;
    @(negedge clk);
    check("R6", {1'b0, mode_q}, {1'b0, exp_mode});
  endtask

  task automatic host_start(input int len);
    host_low = 1'b1;
    repeat (len) @(negedge clk);
    host_low = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {drv_oe, mode_q}, 2'b00);
    check("R1", {clkrun, 1'b0}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {drv_oe, mode_q}, 2'b00);

    // table walk: host-started frames, local quiet start disabled
    for (int i = 0; i < 6; i++) begin
      logic [NS-1:0] rq;
      rq  = VEC[i][20:4];
      req = rq;
      host_start(4);
      slots_check(rq);
      req = '0;
      stop_pulse(int'(VEC[i][3:1]), VEC[i][0]);
    end

    // enter quiet mode with an empty frame
    host_start(5);
    slots_check('0);
    stop_pulse(2, 1'b1);

    // quiet mode but local enable off: no start (R8)
    req = 17'h00010;
    repeat (5) begin
      @(negedge clk);
      check("R8", {drv_oe, 1'b0}, 2'b00);
    end

    // enable: one-clock local start (R7)
    quiet_en = 1'b1;
    @(negedge clk);
    check("R7", {drv_oe, drv}, 2'b10);
    host_low = 1'b1;
    @(negedge clk);
    check("R7", {drv_oe, drv}, 2'b01);
    repeat (2) @(negedge clk);
    host_low = 1'b0;
    slots_check(17'h00010);
    req = '0;
    stop_pulse(3, 1'b0);

    // continuous mode with enable on: still no start (R8)
    req = 17'h00080;
    repeat (6) begin
      @(negedge clk);
      check("R8", {drv_oe, 1'b0}, 2'b00);
    end

    // clock-run request (R9)
    clk_stop = 1'b1;
    @(negedge clk);
    check("R9", {clkrun, 1'b0}, 2'b10);
    req = 17'h00001;
    @(negedge clk);
    check("R9", {clkrun, 1'b0}, 2'b00);
    req = 17'h10000;
    @(negedge clk);
    check("R9", {clkrun, 1'b0}, 2'b10);
    clk_stop = 1'b0;
    @(negedge clk);
    check("R9", {clkrun, 1'b0}, 2'b00);
    req = '0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule